// File: doc/BRIEF.md
# Parallel Port Bus Cycle Sequencer

This block moves one word at a time between a core-side register set and an external bus that shares its address and data lines. Every access starts with an address phase: the address is driven on the shared lines and an address-strobe output is held high. A data phase follows, in which a write strobe (transmit) or a read strobe (receive) is driven low. The bus side is timed in peripheral clock periods, and one peripheral period equals two core clock cycles. The divider restarts at the start of every access, so the length of an access in core cycles depends only on the programmed settings.

Software programs an external address and a signed step. It then either writes the transmit buffer (transmit direction) or reads the receive buffer (receive direction) to launch an access. Because the access length is known in advance, the core can do other work and come back once the computed number of cycles has passed. A chain-load input from a descriptor engine stalls all register writes while it is high. Register reads are always served in the same cycle.

Register map (3-bit address): 0 control, 1 external address, 2 external step, 3 transmit buffer, 4 receive buffer, 5 status (bit 0 = busy). Control fields: bit 0 enable, bit 1 direction (1 = transmit, 0 = receive), bits 5:2 duration, bit 6 bus-hold enable.

Top module: `ppseq_top`

## Requirements
- R1: After reset busy_o, ale_o and ad_oe_o are 0, rd_n_o and wr_n_o are 1, and the control and external address registers read as 0.
- R2: The address phase lasts exactly 6 core cycles (3 peripheral periods) whatever the duration and bus-hold settings. During it ale_o is 1, ad_oe_o is 1 and ad_o carries the external address.
- R3: The data phase follows the address phase at once and lasts 2×L core cycles, where L = duration + bus-hold bit and a duration of 0 counts as 1.
- R4: busy_o (status bit 0) is 1 for exactly 2×(3+L) core cycles per access. While it is 0, no strobe is active and the bus is not driven.
- R5: ale_o, rd_n_o low and wr_n_o low never overlap. While wr_n_o is low, ad_o carries the transmit buffer with ad_oe_o high. While rd_n_o is low, ad_oe_o is 0.
- R6: While chain_busy_i is 1, reg_wr_ready_o is 0 and no register write takes effect. Reads still return current contents.
- R7: A write to the transmit buffer (address 3) while busy is held off with reg_wr_ready_o low until the access ends. It is then accepted and starts the next access.
- R8: In receive direction, a read strobe on the receive buffer (address 4) while idle starts an access. ad_i is captured at the end of the data phase. A read before then returns the previous value and does not start another access.
- R9: After each access the external address gains the step, taken as two's complement and modulo 2^16.
- R10: With enable at 0, a transmit buffer write stores the word but starts no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_busy_i | input | 1 | Descriptor chain load in progress; stalls writes |
| reg_wr_en_i | input | 1 | Register write request |
| reg_wr_addr_i | input | 3 | Register write address |
| reg_wr_data_i | input | 16 | Register write data |
| reg_wr_ready_o | output | 1 | Write accepted on this edge when high |
| reg_rd_en_i | input | 1 | Read strobe (launches receive access) |
| reg_rd_addr_i | input | 3 | Register read address |
| reg_rd_data_o | output | 16 | Register read data |
| busy_o | output | 1 | Access in progress |
| ad_o | output | 16 | Shared address/data lines, out |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | 16 | Shared address/data lines, in |
| ale_o | output | 1 | Address strobe, active high |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
The assertions check on every cycle that the address strobe runs exactly six cycles, that a data strobe follows it at once, that the strobes never overlap, that the bus is released during reads and quiet when idle, and that writes are refused under chain load or when the transmit buffer is written while busy. The exact data-phase length for every duration and bus-hold pair, the total busy time, the word on the bus, the address stepping, the receive capture, and the rule that an early read does not restart an access can only be shown by the bench's sweeps, which compute the expected counts from the formula.

// File: rtl/ppseq_pkg.sv
package ppseq_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_ALE = 2'd1, PH_DATA = 2'd2} phase_t;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_EADDR = 3'd1;
  localparam logic [2:0] RA_ESTEP = 3'd2;
  localparam logic [2:0] RA_TX    = 3'd3;
  localparam logic [2:0] RA_RX    = 3'd4;
  localparam logic [2:0] RA_STAT  = 3'd5;

  localparam int ALE_PCLKS = 3;
endpackage

// File: rtl/ppseq_timer.sv
module ppseq_timer
  import ppseq_pkg::*;
#(
  parameter int DUR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             bhold_i,
  output phase_t           phase_o,
  output logic             done_o
);
  localparam int CW = DUR_W + 1;

  phase_t        phase_q, phase_d;
  logic          half_q, half_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;
  logic [CW-1:0] eff_len;

  // zero duration still gives one strobe period
  assign eff_len = ((dur_i == '0) ? CW'(1) : CW'(dur_i)) + CW'(bhold_i);

  always_comb begin
    phase_d = phase_q;
    half_d  = half_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    done_o  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_ALE;
          half_d  = 1'b0;
          cnt_d   = '0;
          len_d   = eff_len;
        end
      end
      PH_ALE: begin
        half_d = ~half_q;
        if (half_q) begin
          if (cnt_q == CW'(ALE_PCLKS - 1)) begin
            phase_d = PH_DATA;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      PH_DATA: begin
        half_d = ~half_q;
        if (half_q) begin
          if (cnt_q == len_q - CW'(1)) begin
            phase_d = PH_IDLE;
            done_o  = 1'b1;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      half_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      phase_q <= phase_d;
      half_q  <= half_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/ppseq_regs.sv
module ppseq_regs
  import ppseq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DUR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_acc_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             rx_we_i,
  input  logic [DW-1:0]    rx_data_i,
  output logic             en_o,
  output logic             dir_tx_o,
  output logic [DUR_W-1:0] dur_o,
  output logic             bhold_o,
  output logic [DW-1:0]    eaddr_o,
  output logic [DW-1:0]    tx_o
);
  localparam int CTL_W = DUR_W + 3;

  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]    eaddr_q, eaddr_d;
  logic [DW-1:0]    estep_q, estep_d;
  logic [DW-1:0]    tx_q, tx_d;
  logic [DW-1:0]    rx_q, rx_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    eaddr_d = eaddr_q;
    estep_d = estep_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    if (done_i) eaddr_d = eaddr_q + estep_q;
    if (rx_we_i) rx_d = rx_data_i;
    if (wr_acc_i) begin
      case (wr_addr_i)
        RA_CTRL:  ctrl_d  = wr_data_i[CTL_W-1:0];
        RA_EADDR: eaddr_d = wr_data_i;
        RA_ESTEP: estep_d = wr_data_i;
        RA_TX:    tx_d    = wr_data_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      eaddr_q <= '0;
      estep_q <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      eaddr_q <= eaddr_d;
      estep_q <= estep_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
    end
  end

  always_comb begin
    case (rd_addr_i)
      RA_CTRL:  rd_data_o = DW'(ctrl_q);
      RA_EADDR: rd_data_o = eaddr_q;
      RA_ESTEP: rd_data_o = estep_q;
      RA_TX:    rd_data_o = tx_q;
      RA_RX:    rd_data_o = rx_q;
      RA_STAT:  rd_data_o = DW'(busy_i);
      default:  rd_data_o = '0;
    endcase
  end

  assign en_o     = ctrl_q[0];
  assign dir_tx_o = ctrl_q[1];
  assign dur_o    = ctrl_q[2 +: DUR_W];
  assign bhold_o  = ctrl_q[2 + DUR_W];
  assign eaddr_o  = eaddr_q;
  assign tx_o     = tx_q;
endmodule

// File: rtl/ppseq_top.sv
module ppseq_top
  import ppseq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DUR_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chain_busy_i,
  input  logic          reg_wr_en_i,
  input  logic [2:0]    reg_wr_addr_i,
  input  logic [DW-1:0] reg_wr_data_i,
  output logic          reg_wr_ready_o,
  input  logic          reg_rd_en_i,
  input  logic [2:0]    reg_rd_addr_i,
  output logic [DW-1:0] reg_rd_data_o,
  output logic          busy_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  input  logic [DW-1:0] ad_i,
  output logic          ale_o,
  output logic          rd_n_o,
  output logic          wr_n_o
);
  phase_t           phase;
  logic             done;
  logic             en, dir_tx, bhold;
  logic [DUR_W-1:0] dur;
  logic [DW-1:0]    eaddr, txw;
  logic             wr_acc, tx_go, rx_go, start;
  logic [DW-1:0]    addr_snap_q;
  logic             dir_snap_q;

  assign busy_o         = (phase != PH_IDLE);
  assign reg_wr_ready_o = !chain_busy_i && !(busy_o && reg_wr_addr_i == RA_TX);
  assign wr_acc         = reg_wr_en_i && reg_wr_ready_o;
  assign tx_go          = wr_acc && reg_wr_addr_i == RA_TX && en && dir_tx;
  assign rx_go          = reg_rd_en_i && reg_rd_addr_i == RA_RX && en && !dir_tx && !busy_o;
  assign start          = (tx_go || rx_go) && !busy_o;

  ppseq_regs #(.DW(DW), .DUR_W(DUR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_acc_i  (wr_acc),
    .wr_addr_i (reg_wr_addr_i),
    .wr_data_i (reg_wr_data_i),
    .rd_addr_i (reg_rd_addr_i),
    .rd_data_o (reg_rd_data_o),
    .busy_i    (busy_o),
    .done_i    (done),
    .rx_we_i   (done && !dir_snap_q),
    .rx_data_i (ad_i),
    .en_o      (en),
    .dir_tx_o  (dir_tx),
    .dur_o     (dur),
    .bhold_o   (bhold),
    .eaddr_o   (eaddr),
    .tx_o      (txw)
  );

  ppseq_timer #(.DUR_W(DUR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .dur_i   (dur),
    .bhold_i (bhold),
    .phase_o (phase),
    .done_o  (done)
  );

  // address and direction are frozen for the whole access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_snap_q <= '0;
      dir_snap_q  <= 1'b0;
    end else if (start) begin
      addr_snap_q <= eaddr;
      dir_snap_q  <= dir_tx;
    end
  end

  assign ale_o   = (phase == PH_ALE);
  assign wr_n_o  = !(phase == PH_DATA && dir_snap_q);
  assign rd_n_o  = !(phase == PH_DATA && !dir_snap_q);
  assign ad_oe_o = ale_o || !wr_n_o;
  assign ad_o    = ale_o ? addr_snap_q : txw;
endmodule

// File: rtl/ppseq_checker.sv
module ppseq_checker
  import ppseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       chain_busy_i,
  input logic [2:0] reg_wr_addr_i,
  input logic       reg_wr_ready_o,
  input logic       busy_o,
  input logic       ale_o,
  input logic       rd_n_o,
  input logic       wr_n_o,
  input logic       ad_oe_o
);
  logic [7:0] ale_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ale_run_q <= '0;
    else if (ale_o) ale_run_q <= ale_run_q + 8'd1;
    else            ale_run_q <= '0;
  end

  a_r2_ale_six: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_o) |-> ale_run_q == 8'd6);

  a_r3_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_o) |-> (!rd_n_o || !wr_n_o));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ale_o && rd_n_o && wr_n_o && !ad_oe_o));

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ale_o, !rd_n_o, !wr_n_o}) <= 1);

  a_r5_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe_o);

  a_r6_chain_stall: assert property (@(posedge clk) disable iff (!rst_n)
    chain_busy_i |-> !reg_wr_ready_o);

  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && reg_wr_addr_i == RA_TX) |-> !reg_wr_ready_o);
endmodule

bind ppseq_top ppseq_checker u_ppseq_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .chain_busy_i   (chain_busy_i),
  .reg_wr_addr_i  (reg_wr_addr_i),
  .reg_wr_ready_o (reg_wr_ready_o),
  .busy_o         (busy_o),
  .ale_o          (ale_o),
  .rd_n_o         (rd_n_o),
  .wr_n_o         (wr_n_o),
  .ad_oe_o        (ad_oe_o)
);

// File: tb/test_ppseq_top.sv
module test_ppseq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chain_busy_i;
  logic        reg_wr_en_i;
  logic [2:0]  reg_wr_addr_i;
  logic [15:0] reg_wr_data_i;
  logic        reg_wr_ready_o;
  logic        reg_rd_en_i;
  logic [2:0]  reg_rd_addr_i;
  logic [15:0] reg_rd_data_o;
  logic        busy_o;
  logic [15:0] ad_o;
  logic        ad_oe_o;
  logic [15:0] ad_i;
  logic        ale_o, rd_n_o, wr_n_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] ea;

  always #4 clk = ~clk;

  ppseq_top i_ppseq_top (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start just after a negedge and end just after a negedge
  task automatic reg_write(input logic [2:0] a, input logic [15:0] d, output int stalls);
    stalls = 0;
    reg_wr_en_i = 1'b1; reg_wr_addr_i = a; reg_wr_data_i = d;
    forever begin
      #1;
      if (reg_wr_ready_o) break;
      @(negedge clk);
      stalls++;
    end
    @(negedge clk);
    reg_wr_en_i = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, input bit trig, output logic [15:0] v);
    reg_rd_addr_i = a; reg_rd_en_i = trig;
    #1 v = reg_rd_data_o;
    @(negedge clk);
    reg_rd_en_i = 1'b0;
  endtask

  task automatic observe(input logic [15:0] xa, input logic [15:0] xd,
                         output int nb, output int na, output int ns, output int errs);
    nb = 0; na = 0; ns = 0; errs = 0;
    while (busy_o && nb < 200) begin
      if (ale_o) begin
        na++;
        if (!ad_oe_o || ad_o != xa) errs++;
      end
      if (!wr_n_o) begin
        ns++;
        if (!ad_oe_o || ad_o != xd) errs++;
      end
      if (!rd_n_o) begin
        ns++;
        if (ad_oe_o) errs++;
      end
      nb++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int st, nb, na, ns, er, quiet;
    logic [15:0] v;
    rst_n = 1'b0; chain_busy_i = 1'b0; reg_wr_en_i = 1'b0; reg_wr_addr_i = '0;
    reg_wr_data_i = '0; reg_rd_en_i = 1'b0; reg_rd_addr_i = '0; ad_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!busy_o && !ale_o && !ad_oe_o && rd_n_o && wr_n_o, "R1 pins", int'(busy_o), 0);
    reg_read(3'd0, 1'b0, v); check(v == 16'h0, "R1 ctrl", v, 0);
    reg_read(3'd1, 1'b0, v); check(v == 16'h0, "R1 eaddr", v, 0);

    ea = 16'h1000;
    reg_write(3'd1, ea, st);
    reg_write(3'd2, 16'h0004, st);

    // sweep every duration and bus-hold setting in transmit
    for (int bh = 0; bh < 2; bh++) begin
      for (int dur = 0; dur < 16; dur++) begin
        int l;
        logic [15:0] d;
        l = ((dur == 0) ? 1 : dur) + bh;
        d = 16'hC000 ^ 16'(dur << 4) ^ 16'(bh);
        reg_write(3'd0, 16'(3 | (dur << 2) | (bh << 6)), st);
        reg_write(3'd3, d, st);
        observe(ea, d, nb, na, ns, er);
        check(na == 6, "R2 ale length", na, 6);
        check(ns == 2 * l, "R3 strobe length", ns, 2 * l);
        check(nb == 2 * (3 + l), "R4 busy length", nb, 2 * (3 + l));
        check(er == 0, "R5 bus content", er, 0);
        ea = ea + 16'h0004;
      end
    end
    reg_read(3'd1, 1'b0, v); check(v == ea, "R9 step up", v, ea);
    reg_read(3'd5, 1'b0, v); check(v == 16'h0, "R4 status idle", v, 0);

    // R9 negative step
    reg_write(3'd2, 16'hFFFD, st);
    reg_write(3'd0, 16'(3 | (1 << 2)), st);
    reg_write(3'd3, 16'h5A5A, st);
    observe(ea, 16'h5A5A, nb, na, ns, er);
    check(er == 0, "R9 ale address", er, 0);
    ea = ea - 16'd3;
    reg_read(3'd1, 1'b0, v); check(v == ea, "R9 step down", v, ea);

    // R7 back-pressure on transmit writes
    reg_write(3'd0, 16'(3 | (5 << 2)), st);
    reg_write(3'd3, 16'h1111, st);
    reg_write(3'd3, 16'h2222, st);
    check(st == 16, "R7 stall cycles", st, 16);
    ea = ea - 16'd3;
    observe(ea, 16'h2222, nb, na, ns, er);
    check(nb == 16 && na == 6 && er == 0, "R7 next access", nb, 16);
    ea = ea - 16'd3;

    // R10 disabled port
    reg_write(3'd0, 16'h0002, st);
    reg_write(3'd3, 16'h1234, st);
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      if (busy_o || ale_o || !wr_n_o || ad_oe_o) quiet++;
      @(negedge clk);
    end
    check(quiet == 0, "R10 no activity", quiet, 0);
    reg_read(3'd3, 1'b0, v); check(v == 16'h1234, "R10 stored", v, 16'h1234);

    // R8 receive
    ad_i = 16'hA5C3;
    reg_write(3'd0, 16'(1 | (2 << 2) | (1 << 6)), st);
    reg_read(3'd4, 1'b1, v); check(v == 16'h0, "R8 first read old", v, 0);
    check(busy_o == 1'b1, "R8 access started", int'(busy_o), 1);
    reg_read(3'd4, 1'b1, v); check(v == 16'h0, "R8 early read old", v, 0);
    observe(ea, 16'h0, nb, na, ns, er);
    check(nb == 11, "R8 no restart", nb, 11);
    check(ns == 6 && er == 0, "R5 read strobe", ns, 6);
    quiet = 0;
    for (int i = 0; i < 4; i++) begin
      if (busy_o) quiet++;
      @(negedge clk);
    end
    check(quiet == 0, "R8 stays idle", quiet, 0);
    reg_read(3'd4, 1'b0, v); check(v == 16'hA5C3, "R8 captured", v, 16'hA5C3);
    ea = ea - 16'd3;
    reg_read(3'd1, 1'b0, v); check(v == ea, "R9 after receive", v, ea);

    // R6 chain load stalls writes, reads served
    chain_busy_i = 1'b1;
    reg_wr_en_i = 1'b1; reg_wr_addr_i = 3'd1; reg_wr_data_i = 16'h7777;
    reg_rd_addr_i = 3'd1;
    quiet = 0;
    for (int i = 0; i < 5; i++) begin
      #1;
      if (reg_wr_ready_o) quiet++;
      if (reg_rd_data_o != ea) quiet++;
      @(negedge clk);
    end
    check(quiet == 0, "R6 stalled and readable", quiet, 0);
    chain_busy_i = 1'b0;
    #1 check(reg_wr_ready_o == 1'b1, "R6 released", int'(reg_wr_ready_o), 1);
    @(negedge clk);
    reg_wr_en_i = 1'b0;
    reg_read(3'd1, 1'b0, v); check(v == 16'h7777, "R6 write lands", v, 16'h7777);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule